// File: doc/BRIEF.md
# Rotating Load Aligner

This block sits on the load-data return path of a 32-bit little-endian core. It lets the core load a word from any byte address without trapping and without a second memory access. The memory is always read at the requested address with its two low bits cleared. The returned word is then rotated right by eight bits for every byte of offset, so the byte at the requested address ends up in the least significant byte of the result.

Byte and halfword loads use the same rotation and then keep only the low 8 or 16 bits of the rotated word. The remaining upper bits are either cleared or filled with copies of the top kept bit. The rotation and masking are combinational from the memory data. The result is captured in an output register and is marked by a valid pulse that lasts one cycle for each load.

Top module: `load_rotator`

## Requirements
- R1: `mem_addr` always equals `ld_addr` with bits [1:0] forced to zero.
- R2: A word load (`ld_size` 2'b10, and also the otherwise unused code 2'b11) returns `mem_rdata` rotated right by 8×`ld_addr[1:0]` bits. For an offset of 0 the word is passed through unchanged.
- R3: An unsigned byte load (`ld_size` 2'b00, `ld_signed` 0) returns bits [7:0] of the rotated word, with bits [31:8] cleared.
- R4: A signed byte load (`ld_size` 2'b00, `ld_signed` 1) returns bits [7:0] of the rotated word, with bit 7 copied into bits [31:8].
- R5: A halfword load (`ld_size` 2'b01) returns bits [15:0] of the rotated word. Bits [31:16] are cleared when `ld_signed` is 0 and are copies of bit 15 when `ld_signed` is 1. Odd offsets follow the same rotation, so offset 3 yields byte 0 above byte 3.
- R6: For each cycle in which `ld_valid` is high at a rising edge, `res_data` and `res_valid` change one edge later. `res_valid` is high for exactly that one cycle per load.
- R7: While no load is presented, `res_data` keeps its last value, whatever `ld_addr`, `ld_size` or `mem_rdata` do.
- R8: While `rst_n` is low, `res_valid` and `res_data` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| ld_valid | input | 1 | A load is presented this cycle |
| ld_addr | input | 32 | Requested byte address |
| ld_size | input | 2 | Load width: 00 byte, 01 halfword, 10 or 11 word |
| ld_signed | input | 1 | Sign-extend byte and halfword results |
| mem_addr | output | 32 | Word-aligned address sent to memory |
| mem_rdata | input | 32 | Word returned by memory in the same cycle |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_data | output | 32 | Aligned, extended load result |

## Verification
The assertions take for granted that `mem_rdata` is valid in the same cycle as `ld_valid`, which means memory returns data combinationally for the aligned address. They also assume that the size and signed inputs are steady across the capturing edge. The bench drives every input on the falling clock edge, so each of them is stable over the rising edge that captures it. Memory is modelled as a fixed word per vector, applied together with the address. The vectors cover all four offsets for each load width, both sign settings, and words whose top kept bit is set in some cases and clear in others.

// File: rtl/load_rotator.sv
module load_rotator #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic              ld_signed,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              res_valid,
  output logic [DATA_W-1:0] res_data
);
  localparam int OFF_W = $clog2(DATA_W / 8);

  logic [OFF_W-1:0]    off;
  logic [2*DATA_W-1:0] dbl;
  logic [DATA_W-1:0]   rot;
  logic [DATA_W-1:0]   shaped;

  assign off      = ld_addr[OFF_W-1:0];
  assign mem_addr = {ld_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign dbl      = {mem_rdata, mem_rdata} >> {off, 3'b000};
  assign rot      = dbl[DATA_W-1:0];

  always_comb begin
    case (ld_size)
      2'b00:   shaped = {{(DATA_W-8){ld_signed & rot[7]}}, rot[7:0]};
      2'b01:   shaped = {{(DATA_W-16){ld_signed & rot[15]}}, rot[15:0]};
      default: shaped = rot;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= ld_valid;
      if (ld_valid) res_data <= shaped;
    end
  end
endmodule

// File: rtl/load_rotator_chk.sv
module load_rotator_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ld_valid,
  input logic [ADDR_W-1:0] ld_addr,
  input logic [1:0]        ld_size,
  input logic              ld_signed,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_rdata,
  input logic              res_valid,
  input logic [DATA_W-1:0] res_data
);
  p_aligned_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr[1:0] == 2'b00 && mem_addr[ADDR_W-1:2] == ld_addr[ADDR_W-1:2]);

  p_word_passthru_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_size[1] && ld_addr[1:0] == 2'b00) |=> res_data == $past(mem_rdata));

  p_byte_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_size == 2'b00 && !ld_signed) |=> res_data[DATA_W-1:8] == '0);

  p_byte_sext_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_size == 2'b00 && ld_signed) |=> res_data[DATA_W-1:8] == {(DATA_W-8){res_data[7]}});

  p_half_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_size == 2'b01) |=>
      res_data[DATA_W-1:16] == {(DATA_W-16){$past(ld_signed) & res_data[15]}});

  p_valid_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |=> res_valid);

  p_valid_drops_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> !res_valid);

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_valid |=> $stable(res_data));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r8: assert (res_valid == 1'b0 && res_data == '0);
    end
  end
endmodule

bind load_rotator load_rotator_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
  .ld_size(ld_size), .ld_signed(ld_signed), .mem_addr(mem_addr),
  .mem_rdata(mem_rdata), .res_valid(res_valid), .res_data(res_data)
);

// File: tb/load_rotator_bench.sv
`timescale 1ns/1ps
module load_rotator_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0;
  logic [31:0] ld_addr = '0;
  logic [1:0]  ld_size = '0;
  logic        ld_signed = 1'b0;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        res_valid;
  logic [31:0] res_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  load_rotator u_load_rotator (
    .clk(clk), .rst_n(rst_n), .ld_valid(ld_valid), .ld_addr(ld_addr),
    .ld_size(ld_size), .ld_signed(ld_signed), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .res_valid(res_valid), .res_data(res_data)
  );

  // {addr, size, signed, rdata, expected}
  localparam logic [98:0] VEC [0:12] = '{
    {32'h0000_1000, 2'b10, 1'b0, 32'hA1B2_C3D4, 32'hA1B2_C3D4},
    {32'h0000_1001, 2'b10, 1'b0, 32'hA1B2_C3D4, 32'hD4A1_B2C3},
    {32'h0000_1002, 2'b10, 1'b1, 32'hA1B2_C3D4, 32'hC3D4_A1B2},
    {32'h0000_1003, 2'b11, 1'b0, 32'hA1B2_C3D4, 32'hB2C3_D4A1},
    {32'h0000_1000, 2'b00, 1'b0, 32'hA1B2_C3D4, 32'h0000_00D4},
    {32'h0000_1001, 2'b00, 1'b1, 32'hA1B2_C3D4, 32'hFFFF_FFC3},
    {32'h0000_1003, 2'b00, 1'b0, 32'hA1B2_C3D4, 32'h0000_00A1},
    {32'h0000_1002, 2'b01, 1'b0, 32'hA1B2_C3D4, 32'h0000_A1B2},
    {32'h0000_1003, 2'b01, 1'b1, 32'hA1B2_C3D4, 32'hFFFF_D4A1},
    {32'h0000_1001, 2'b01, 1'b0, 32'hA1B2_C3D4, 32'h0000_B2C3},
    {32'h0000_2002, 2'b00, 1'b1, 32'h7F3E_5A01, 32'h0000_003E},
    {32'h0000_2000, 2'b01, 1'b1, 32'h7F3E_5A01, 32'h0000_5A01},
    {32'h0000_2003, 2'b01, 1'b1, 32'h7F3E_5A01, 32'h0000_017F}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [31:0] a, input logic [1:0] s, input logic sg,
                         input logic [31:0] w, input logic [31:0] exp, input string req);
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = a; ld_size = s; ld_signed = sg; mem_rdata = w;
    #1;
    check(mem_addr == {a[31:2], 2'b00}, "R1 mem_addr", mem_addr, {a[31:2], 2'b00});
    @(negedge clk);
    ld_valid = 1'b0;
    check(res_valid === 1'b1, "R6 res_valid", {31'd0, res_valid}, 32'd1);
    check(res_data === exp, req, res_data, exp);
  endtask

  initial begin
    #1;
    check(res_valid === 1'b0, "R8 reset valid", {31'd0, res_valid}, 32'd0);
    check(res_data === 32'd0, "R8 reset data", res_data, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < 13; i++) begin
      automatic logic [98:0] v = VEC[i];
      automatic string req = (v[97:96] == 2'b00) ? (v[64] ? "R4 signed byte" : "R3 unsigned byte")
                           : (v[97:96] == 2'b01) ? "R5 halfword" : "R2 word rotate";
      do_load(v[98:67], v[66:65], v[64], v[63:32], v[31:0], req);
    end

    // R6: single pulse, then low with no load
    do_load(32'h0000_3001, 2'b10, 1'b0, 32'h1122_3344, 32'h4411_2233, "R2 word rotate off1");
    @(negedge clk);
    check(res_valid === 1'b0, "R6 pulse ends", {31'd0, res_valid}, 32'd0);

    // R7: inputs change without a load, result holds
    ld_addr = 32'h0000_4002; ld_size = 2'b00; ld_signed = 1'b1; mem_rdata = 32'hDEAD_BEEF;
    repeat (2) @(negedge clk);
    check(res_data === 32'h4411_2233, "R7 hold idle", res_data, 32'h4411_2233);
    check(res_valid === 1'b0, "R7 no valid idle", {31'd0, res_valid}, 32'd0);

    // R6: back-to-back loads each give a pulse
    @(negedge clk);
    ld_valid = 1'b1; ld_addr = 32'h0000_5000; ld_size = 2'b00; ld_signed = 1'b0; mem_rdata = 32'h0000_0080;
    @(negedge clk);
    check(res_valid === 1'b1 && res_data === 32'h0000_0080, "R3 back-to-back first", res_data, 32'h0000_0080);
    ld_signed = 1'b1;
    @(negedge clk);
    ld_valid = 1'b0;
    check(res_valid === 1'b1 && res_data === 32'hFFFF_FF80, "R4 back-to-back second", res_data, 32'hFFFF_FF80);

    // R8: reset mid-run clears outputs
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(res_data === 32'd0 && res_valid === 1'b0, "R8 async reset", res_data, 32'd0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule